// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a small data cache placed between a processor port that moves one byte at a time and a backing memory that moves whole lines. A read or write that hits is served in the same cycle as the lookup. A miss holds the processor off and picks a victim way in the indexed set. If that victim holds modified data, the victim line is first written back to memory. The aligned line is then read from memory and installed. Writes that miss allocate the line first and then merge the byte, so all stores land in the cache and reach memory only when the line is evicted.

The processor keeps its request, address, write flag and write byte steady while `cpuReady` is low. When ready goes high, the request is complete: read data is valid and a write takes effect at the next clock edge. A parameter chooses how a full set is handled. The fixed rule always evicts way 0. The other rule keeps one bit per set that tracks the least-recently-used way.

Top module: `twoway_wb_cache`

## Requirements
- R1: A byte address is split, from most to least significant, into a 6-bit tag [9:4], a 2-bit set index [3:2] and a 2-bit byte offset [1:0]. On the line-wide memory ports, byte offset k occupies bits [8k+7:8k].
- R2: After reset, every line is invalid and clean, and every replacement bit is cleared. While idle, `cpuReady` is high and both memory requests are low. The first access to any address misses.
- R3: A request hits only when a way of the indexed set is valid and its tag equals the address tag. On a read hit, `cpuReady` is high in the request cycle, `cpuRData` returns the stored byte, and no memory request is raised.
- R4: A write hit changes only the addressed byte, marks the line modified and raises no memory request.
- R5: On a read miss, `cpuReady` is low until the fill completes. The line is read from memory at the address with its offset bits cleared. The line is installed valid and clean, and the request then completes with the memory byte.
- R6: If a way of the indexed set is invalid, the miss fills it (way 0 before way 1) and leaves the valid line in place.
- R7: With `USE_LRU`=0 and both ways valid, a miss evicts way 0 and way 1 is kept.
- R8: With `USE_LRU`=1, each set keeps one bit naming its least-recently-used way. Every hit and every fill marks the other way as least recent. A miss in a full set evicts the way that the bit names.
- R9: A modified victim is written to memory as a whole line, at its own tag and set with offset zero, before the fill read starts. A clean victim causes no memory write.
- R10: A write miss allocates the line in the same way as a read miss, then merges the byte and marks the line modified. A later eviction of that line writes the byte back to memory.
- R11: The memory read and write requests are never high together. Each is held, with a steady address, until `memDone` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Processor access request |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 10 | Byte address |
| cpuWData | input | 8 | Byte to write |
| cpuRData | output | 8 | Byte read, valid while `cpuReady` is high on a read |
| cpuReady | output | 1 | High when the access completes this cycle; low while stalled |
| memRdReq | output | 1 | Line read (fill) request |
| memWrReq | output | 1 | Line write (write-back) request |
| memAddr | output | 10 | Line base address of the current memory request |
| memWLine | output | 32 | Line data being written back |
| memRLine | input | 32 | Line data returned for a fill |
| memDone | input | 1 | One-cycle pulse ending the current memory request |

## Verification
The bench builds two copies of the cache side by side, driven by the same processor stimulus. One copy uses `USE_LRU`=0 and the other `USE_LRU`=1, and each has its own memory model with a three-cycle response. Running both under the same access sequence exposes where the two eviction rules diverge: a set is filled, one way is touched again, and a third tag then arrives. Under the same sequence, the fixed rule evicts the recently used line while the tracking rule evicts the other one. With the default geometry, a few tags per set are enough to reach invalid-way fills, dirty and clean evictions, and write-miss allocation.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_WBACK = 2'd1,
    CS_FILL  = 2'd2
  } ctl_state_t;

  typedef struct packed {
    logic hitAccess;   // any hit: update recency
    logic wrHit;       // write hit: merge byte, mark modified
    logic captureMiss; // latch miss context and victim
    logic install;     // write fill line into the victim way
    logic wbAddrSel;   // memory address shows the victim line
  } ctl_strobe_t;

endpackage

// File: rtl/wbc_datapath.sv
module wbc_datapath
  import wbc_pkg::*;
#(
  parameter int TAG_W   = 6,
  parameter int SET_W   = 2,
  parameter int OFF_W   = 2,
  parameter bit USE_LRU = 1'b0,
  localparam int AW     = TAG_W + SET_W + OFF_W,
  localparam int LINE_W = 8 << OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AW-1:0]     cpuAddr,
  input  logic [7:0]        cpuWData,
  input  ctl_strobe_t       strb,
  input  logic [LINE_W-1:0] memRLine,
  output logic              hit,
  output logic              victimDirty,
  output logic [7:0]        cpuRData,
  output logic [AW-1:0]     memAddr,
  output logic [LINE_W-1:0] memWLine
);
  localparam int SETS = 1 << SET_W;
  localparam int WAYS = 2;

  logic [TAG_W-1:0]  tagMem   [SETS][WAYS];
  logic [LINE_W-1:0] dataMem  [SETS][WAYS];
  logic [WAYS-1:0]   validMem [SETS];
  logic [WAYS-1:0]   dirtyMem [SETS];
  logic [SETS-1:0]   lruWay;

  logic [TAG_W-1:0] curTag;
  logic [SET_W-1:0] curSet;
  logic [OFF_W-1:0] curOff;
  assign curTag = cpuAddr[AW-1 -: TAG_W];
  assign curSet = cpuAddr[OFF_W +: SET_W];
  assign curOff = cpuAddr[OFF_W-1:0];

  logic [WAYS-1:0] wayHit;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign wayHit[w] = validMem[curSet][w] && (tagMem[curSet][w] == curTag);
  end

  logic hitWay;
  logic [LINE_W-1:0] hitLine;
  assign hit      = |wayHit;
  assign hitWay   = wayHit[1];
  assign hitLine  = dataMem[curSet][hitWay];
  assign cpuRData = hitLine[{curOff, 3'b000} +: 8];

  logic vicWay;
  always_comb begin
    if (!validMem[curSet][0])      vicWay = 1'b0;
    else if (!validMem[curSet][1]) vicWay = 1'b1;
    else                           vicWay = USE_LRU ? lruWay[curSet] : 1'b0;
  end
  assign victimDirty = validMem[curSet][vicWay] && dirtyMem[curSet][vicWay];

  logic [TAG_W-1:0]  missTag, vicTagQ;
  logic [SET_W-1:0]  missSet;
  logic              vicWayQ;
  logic [LINE_W-1:0] vicLineQ;

  always_ff @(posedge clk) begin
    if (strb.captureMiss) begin
      missTag  <= curTag;
      missSet  <= curSet;
      vicWayQ  <= vicWay;
      vicTagQ  <= tagMem[curSet][vicWay];
      vicLineQ <= dataMem[curSet][vicWay];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validMem[s] <= '0;
        dirtyMem[s] <= '0;
      end
      lruWay <= '0;
    end else begin
      if (strb.hitAccess) lruWay[curSet] <= ~hitWay;
      if (strb.wrHit)     dirtyMem[curSet][hitWay] <= 1'b1;
      if (strb.install) begin
        validMem[missSet][vicWayQ] <= 1'b1;
        dirtyMem[missSet][vicWayQ] <= 1'b0;
        lruWay[missSet]            <= ~vicWayQ;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrHit) dataMem[curSet][hitWay][{curOff, 3'b000} +: 8] <= cpuWData;
    if (strb.install) begin
      tagMem[missSet][vicWayQ]  <= missTag;
      dataMem[missSet][vicWayQ] <= memRLine;
    end
  end

  assign memAddr  = strb.wbAddrSel ? {vicTagQ, missSet, {OFF_W{1'b0}}}
                                   : {missTag, missSet, {OFF_W{1'b0}}};
  assign memWLine = vicLineQ;

endmodule

// File: rtl/wbc_control.sv
module wbc_control
  import wbc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        cpuWe,
  input  logic        hit,
  input  logic        victimDirty,
  input  logic        memDone,
  output ctl_strobe_t strb,
  output logic        cpuReady,
  output logic        memRdReq,
  output logic        memWrReq
);
  ctl_state_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= CS_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    cpuReady  = 1'b0;
    memRdReq  = 1'b0;
    memWrReq  = 1'b0;
    unique case (state)
      CS_IDLE: begin
        cpuReady = !cpuReq || hit;
        if (cpuReq && hit) begin
          strb.hitAccess = 1'b1;
          strb.wrHit     = cpuWe;
        end else if (cpuReq) begin
          strb.captureMiss = 1'b1;
          nextState        = victimDirty ? CS_WBACK : CS_FILL;
        end
      end
      CS_WBACK: begin
        memWrReq       = 1'b1;
        strb.wbAddrSel = 1'b1;
        if (memDone) nextState = CS_FILL;
      end
      CS_FILL: begin
        memRdReq = 1'b1;
        if (memDone) begin
          strb.install = 1'b1;
          nextState    = CS_IDLE;
        end
      end
      default: nextState = CS_IDLE;
    endcase
  end

endmodule

// File: rtl/twoway_wb_cache.sv
module twoway_wb_cache
  import wbc_pkg::*;
#(
  parameter int TAG_W   = 6,
  parameter int SET_W   = 2,
  parameter int OFF_W   = 2,
  parameter bit USE_LRU = 1'b0
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cpuReq,
  input  logic                         cpuWe,
  input  logic [TAG_W+SET_W+OFF_W-1:0] cpuAddr,
  input  logic [7:0]                   cpuWData,
  output logic [7:0]                   cpuRData,
  output logic                         cpuReady,
  output logic                         memRdReq,
  output logic                         memWrReq,
  output logic [TAG_W+SET_W+OFF_W-1:0] memAddr,
  output logic [(8<<OFF_W)-1:0]        memWLine,
  input  logic [(8<<OFF_W)-1:0]        memRLine,
  input  logic                         memDone
);
  ctl_strobe_t strb;
  logic hit, victimDirty;

  wbc_control u_ctl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .hit(hit),
    .victimDirty(victimDirty), .memDone(memDone), .strb(strb),
    .cpuReady(cpuReady), .memRdReq(memRdReq), .memWrReq(memWrReq)
  );

  wbc_datapath #(.TAG_W(TAG_W), .SET_W(SET_W), .OFF_W(OFF_W), .USE_LRU(USE_LRU)) u_dp (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWData(cpuWData), .strb(strb),
    .memRLine(memRLine), .hit(hit), .victimDirty(victimDirty),
    .cpuRData(cpuRData), .memAddr(memAddr), .memWLine(memWLine)
  );

endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rstN,
  input logic          cpuReq,
  input logic          cpuReady,
  input logic          memRdReq,
  input logic          memWrReq,
  input logic          memDone,
  input logic [AW-1:0] memAddr
);
  // R11
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdReq && memWrReq));

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && !memDone) |=> (memRdReq && $stable(memAddr)));

  // R11
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWrReq && !memDone) |=> (memWrReq && $stable(memAddr)));

  // R9
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWrReq) |-> memRdReq);

  // R5
  fill_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq || memWrReq) |-> !cpuReady);

  // R3
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuReady) |-> (!memRdReq && !memWrReq));

endmodule

bind twoway_wb_cache wbc_checker #(.AW(TAG_W + SET_W + OFF_W)) u_chk (
  .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuReady(cpuReady),
  .memRdReq(memRdReq), .memWrReq(memWrReq), .memDone(memDone), .memAddr(memAddr)
);

// File: tb/sim_mem.sv
module sim_mem #(
  parameter int AW    = 10,
  parameter int BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rdReq,
  input  logic                 wrReq,
  input  logic [AW-1:0]        addr,
  input  logic [8*BYTES-1:0]   wLine,
  output logic [8*BYTES-1:0]   rLine,
  output logic                 done
);
  logic [7:0] mem [1<<AW];
  int rdCnt = 0, wrCnt = 0, seq = 0, lastRdSeq = 0, lastWrSeq = 0, cnt = 0;
  logic [AW-1:0] lastRdAddr = '0, lastWrAddr = '0;

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 8'(i) ^ 8'h5A;
    done  = 1'b0;
    rLine = '0;
  end

  always @(posedge clk) begin
    done <= 1'b0;
    if ((rdReq || wrReq) && !done) begin
      if (cnt == 2) begin
        cnt  <= 0;
        done <= 1'b1;
        seq  <= seq + 1;
        if (wrReq) begin
          for (int k = 0; k < BYTES; k++) mem[int'(addr) + k] <= wLine[8*k +: 8];
          wrCnt      <= wrCnt + 1;
          lastWrAddr <= addr;
          lastWrSeq  <= seq + 1;
        end else begin
          for (int k = 0; k < BYTES; k++) rLine[8*k +: 8] <= mem[int'(addr) + k];
          rdCnt      <= rdCnt + 1;
          lastRdAddr <= addr;
          lastRdSeq  <= seq + 1;
        end
      end else begin
        cnt <= cnt + 1;
      end
    end
  end
endmodule

// File: tb/sim_twoway_wb_cache.sv
`timescale 1ns/1ps
module sim_twoway_wb_cache;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic       cpuReq = 1'b0, cpuWe = 1'b0;
  logic [9:0] cpuAddr = '0;
  logic [7:0] cpuWData = '0;

  logic [7:0]  rd0, rd1;
  logic        rdy0, rdy1, mRd0, mRd1, mWr0, mWr1, done0, done1;
  logic [9:0]  mA0, mA1;
  logic [31:0] wl0, wl1, rl0, rl1;

  twoway_wb_cache #(.USE_LRU(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWData(cpuWData), .cpuRData(rd0), .cpuReady(rdy0), .memRdReq(mRd0),
    .memWrReq(mWr0), .memAddr(mA0), .memWLine(wl0), .memRLine(rl0), .memDone(done0));
  twoway_wb_cache #(.USE_LRU(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWData(cpuWData), .cpuRData(rd1), .cpuReady(rdy1), .memRdReq(mRd1),
    .memWrReq(mWr1), .memAddr(mA1), .memWLine(wl1), .memRLine(rl1), .memDone(done1));

  sim_mem m0 (.clk(clk), .rdReq(mRd0), .wrReq(mWr0), .addr(mA0), .wLine(wl0), .rLine(rl0), .done(done0));
  sim_mem m1 (.clk(clk), .rdReq(mRd1), .wrReq(mWr1), .addr(mA1), .wLine(wl1), .rLine(rl1), .done(done1));

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] gold [1024];
  logic [7:0] r0, r1;
  int st0, st1;

  function automatic logic [9:0] mk(input logic [5:0] t, input logic [1:0] s, input logic [1:0] o);
    return {t, s, o};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [9:0] a, input logic [7:0] wd);
    bit d0 = 0, d1 = 0;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWData = wd;
    st0 = 0; st1 = 0;
    forever begin
      #1;
      if (!d0) begin if (rdy0) begin r0 = rd0; d0 = 1; end else st0++; end
      if (!d1) begin if (rdy1) begin r1 = rd1; d1 = 1; end else st1++; end
      if (d0 && d1) break;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    cpuReq = 1'b0; cpuWe = 1'b0;
    if (we) gold[a] = wd;
  endtask

  task automatic t_reset();
    #1;
    chk("R2", "ready idle", int'(rdy0), 1);
    chk("R2", "no fill req", int'(mRd0), 0);
    chk("R2", "no wb req", int'(mWr0), 0);
    access(0, mk(6'h26, 2'd1, 2'd1), 8'h00);
    chk("R2", "first access stalls", int'(st0 > 0), 1);
    chk("R5", "fill byte", int'(r0), int'(gold[mk(6'h26, 2'd1, 2'd1)]));
    chk("R5", "one line read", m0.rdCnt, 1);
    chk("R5", "aligned fill addr", int'(m0.lastRdAddr), int'(mk(6'h26, 2'd1, 2'd0)));
    chk("R9", "clean victim no write", m0.wrCnt, 0);
  endtask

  task automatic t_read_hits();
    int rc = m0.rdCnt;
    for (int o = 0; o < 4; o++) begin
      access(0, mk(6'h26, 2'd1, 2'(o)), 8'h00);
      chk("R3", "hit no stall", st0, 0);
      chk("R1", "byte lane", int'(r0), int'(gold[mk(6'h26, 2'd1, 2'(o))]));
    end
    chk("R3", "hits no traffic", m0.rdCnt, rc);
  endtask

  task automatic t_write_hit();
    int rc = m0.rdCnt, wc = m0.wrCnt;
    access(1, mk(6'h26, 2'd1, 2'd1), 8'hC3);
    chk("R4", "write hit no stall", st0, 0);
    chk("R4", "write hit no traffic", m0.rdCnt + m0.wrCnt, rc + wc);
    for (int o = 0; o < 4; o++) begin
      access(0, mk(6'h26, 2'd1, 2'(o)), 8'h00);
      chk("R4", "only addressed byte changed", int'(r0), int'(gold[mk(6'h26, 2'd1, 2'(o))]));
    end
  endtask

  task automatic t_invalid_way();
    access(0, mk(6'h11, 2'd1, 2'd2), 8'h00);
    chk("R6", "second tag misses", int'(st0 > 0), 1);
    chk("R6", "second tag no write-back", m0.wrCnt, 0);
    access(0, mk(6'h26, 2'd1, 2'd1), 8'h00);
    chk("R6", "first line kept", st0, 0);
    chk("R6", "first line data", int'(r0), 32'hC3);
  endtask

  task automatic t_fixed_evict();
    int wc = m0.wrCnt;
    access(0, mk(6'h3A, 2'd1, 2'd3), 8'h00);
    chk("R7", "third tag misses", int'(st0 > 0), 1);
    chk("R9", "dirty victim written once", m0.wrCnt, wc + 1);
    chk("R9", "write-back address", int'(m0.lastWrAddr), int'(mk(6'h26, 2'd1, 2'd0)));
    chk("R9", "write-back before fill", int'(m0.lastWrSeq < m0.lastRdSeq), 1);
    for (int o = 0; o < 4; o++)
      chk("R9", "whole line in memory", int'(m0.mem[mk(6'h26, 2'd1, 2'(o))]),
          int'(gold[mk(6'h26, 2'd1, 2'(o))]));
    chk("R5", "fill data", int'(r0), int'(gold[mk(6'h3A, 2'd1, 2'd3)]));
    access(0, mk(6'h11, 2'd1, 2'd0), 8'h00);
    chk("R7", "way 1 kept", st0, 0);
    wc = m0.wrCnt;
    access(0, mk(6'h26, 2'd1, 2'd1), 8'h00);
    chk("R7", "evicted line misses", int'(st0 > 0), 1);
    chk("R9", "clean victim no write", m0.wrCnt, wc);
    chk("R9", "refetched modified byte", int'(r0), 32'hC3);
  endtask

  task automatic t_write_miss();
    int rc = m0.rdCnt, wc = m0.wrCnt;
    access(1, mk(6'h30, 2'd3, 2'd2), 8'h7E);
    chk("R10", "write miss stalls", int'(st0 > 0), 1);
    chk("R10", "write miss fetches", m0.rdCnt, rc + 1);
    chk("R10", "write miss no write-back", m0.wrCnt, wc);
    access(0, mk(6'h30, 2'd3, 2'd2), 8'h00);
    chk("R10", "merged byte hits", st0, 0);
    chk("R10", "merged byte", int'(r0), 32'h7E);
    access(0, mk(6'h30, 2'd3, 2'd3), 8'h00);
    chk("R10", "neighbour from memory", int'(r0), int'(gold[mk(6'h30, 2'd3, 2'd3)]));
    access(0, mk(6'h31, 2'd3, 2'd0), 8'h00);
    access(0, mk(6'h32, 2'd3, 2'd0), 8'h00);
    chk("R10", "allocated line dirty", m0.wrCnt, wc + 1);
    chk("R10", "merged byte reached memory", int'(m0.mem[mk(6'h30, 2'd3, 2'd2)]), 32'h7E);
  endtask

  task automatic t_lru();
    access(0, mk(6'h05, 2'd2, 2'd0), 8'h00);
    access(0, mk(6'h09, 2'd2, 2'd0), 8'h00);
    access(0, mk(6'h05, 2'd2, 2'd0), 8'h00);
    chk("R8", "recent way hits", st1, 0);
    access(0, mk(6'h0F, 2'd2, 2'd0), 8'h00);
    chk("R8", "third tag misses lru", int'(st1 > 0), 1);
    access(0, mk(6'h05, 2'd2, 2'd0), 8'h00);
    chk("R8", "recent line kept by lru", st1, 0);
    chk("R7", "fixed rule evicted way 0", int'(st0 > 0), 1);
    access(0, mk(6'h09, 2'd2, 2'd0), 8'h00);
    chk("R8", "least recent line evicted", int'(st1 > 0), 1);
    chk("R8", "lru data", int'(r1), int'(gold[mk(6'h09, 2'd2, 2'd0)]));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) gold[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_hits();
    t_write_hit();
    t_invalid_way();
    t_fixed_evict();
    t_write_miss();
    t_lru();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end
endmodule